// File: doc/BRIEF.md
# Biphasic Stimulation Pulse Sequencer

Digital controller for a single stimulator channel. It drives an external current DAC with an amplitude code and a polarity select, and it controls the switch that shorts the electrodes together. A start request launches a train of biphasic pulses. Each pulse is a first phase, an optional gap, and a second phase of the opposite polarity. After every pulse the electrodes are shorted for a programmed discharge interval. The channel then tests a residual-charge comparator flag. While that flag reports a residual beyond the safety bound, the channel inserts short corrective pulses whose polarity opposes the residual. The number of corrective pulses per cycle is capped. Reaching the cap raises a sticky fault and halts the train.

The amplitude, the phase, gap, short and corrective widths, the inter-pulse period, the phase order, the pulse count and the insertion cap are all latched when the train starts. The charge of each phase is the amplitude code times the phase width, so both are delivered as exact counts: the code is held for exactly the programmed number of clock cycles. The analog DAC, the current source and the residual sensing sit outside the block. The block sees residual sensing only as two flags: over the limit, and sign of the residual.

Top module: `stim_seq`

## Requirements
- R1: After reset `amp_o` is 0, and `pol_o`, `short_o`, `busy_o`, `done_o` and `fault_o` are all 0.
- R2: Each pulse drives `amp_o` equal to the latched amplitude for exactly W cycles with the first polarity. `pol_o`=1 means anodic; `cath_first_i`=1 makes the first phase cathodic (0). It then drives the same amplitude for exactly W cycles with the opposite polarity. A width value of 0 counts as 1.
- R3: Between the two phases `amp_o` is 0 for exactly G gap cycles. With G=0 the second phase follows the first in the next cycle.
- R4: After the second phase `short_o` is 1 for exactly S cycles. `short_o` is never 1 in a cycle with nonzero `amp_o`. `amp_o` is 0 and `short_o` is 0 outside phase, short and corrective intervals.
- R5: The first-phase starts of consecutive pulses are max(P, 2W+G+S+2) cycles apart, with no corrective pulses inserted. P is the period and 2W+G+S+2 is the shortest cycle.
- R6: One check cycle follows the short interval. If `resid_high_i` is 1 there, a corrective pulse of C cycles at the latched amplitude follows. Its polarity is 0 when `resid_pos_i` is 1 and 1 when `resid_pos_i` is 0. Another check cycle follows it, repeating until the flag is 0.
- R7: If the check finds the flag at 1 after M corrective pulses in the current cycle, `fault_o` rises. M is the cap, and M=0 faults at the first high check. The train stops and the channel goes idle. `fault_o` stays 1 until reset, and `start_i` is ignored while it is 1.
- R8: `done_o` is a one-cycle pulse in the cycle after the passing check of the N-th pulse, with `busy_o` already 0. No `done_o` is issued on a fault or an abort.
- R9: `abort_i` returns the channel to idle at the next clock edge, with `amp_o`, `short_o` and `busy_o` at 0.
- R10: `start_i` in idle, with no fault and N≠0, begins the first phase at the next edge. It latches all settings, so later input changes do not affect the train. A start with N=0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch a pulse train |
| abort_i | input | 1 | Stop and return to idle |
| amp_i | input | AMP_W | Phase amplitude code |
| phase_w_i | input | TW | Phase width W in cycles |
| gap_w_i | input | TW | Interphase gap G in cycles |
| short_w_i | input | TW | Electrode short interval S in cycles |
| ins_w_i | input | TW | Corrective pulse width C in cycles |
| period_i | input | PER_W | Pulse period P in cycles |
| pulses_i | input | CNT_W | Pulse count N |
| max_ins_i | input | INS_W | Corrective pulse cap M per cycle |
| cath_first_i | input | 1 | 1: cathodic phase first |
| resid_high_i | input | 1 | Residual charge beyond safe bound |
| resid_pos_i | input | 1 | Residual charge is positive |
| amp_o | output | AMP_W | Amplitude code to DAC |
| pol_o | output | 1 | Polarity select, 1 anodic |
| short_o | output | 1 | Electrode shorting switch |
| busy_o | output | 1 | Train in progress |
| done_o | output | 1 | Train completed pulse |
| fault_o | output | 1 | Sticky insertion cap fault |

## Verification
The bound checker watches, on every cycle, for the safety interlocks that may never break. The shorting switch is never closed while the amplitude is nonzero. The outputs stay quiet when idle, and an abort empties the channel at once. The fault, once raised, stays set and blocks a new start. The done pulse lasts one cycle and arrives with the channel idle. Only the bench's scenarios can show exact phase widths, gap skipping, phase order and the period between pulse starts. The same holds for corrective-pulse polarity versus residual sign, the point at which the insertion cap trips, and settings latched at start. The bench compares whole waveforms and directed cycle positions against values worked out from the programmed counts.

// File: rtl/stim_pkg.sv
package stim_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_PH1, S_GAP, S_PH2, S_SHORT, S_CHECK, S_INSERT, S_WAIT
  } state_e;
endpackage

// File: rtl/stim_timer.sv
module stim_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end
  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/stim_counter.sv
module stim_counter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_o <= '0;
    else if (clr_i)                   cnt_o <= '0;
    else if (inc_i && cnt_o != '1)    cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/stim_seq.sv
module stim_seq
  import stim_pkg::*;
#(
  parameter int AMP_W = 8,
  parameter int TW    = 8,
  parameter int PER_W = 12,
  parameter int CNT_W = 8,
  parameter int INS_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic [AMP_W-1:0] amp_i,
  input  logic [TW-1:0]    phase_w_i,
  input  logic [TW-1:0]    gap_w_i,
  input  logic [TW-1:0]    short_w_i,
  input  logic [TW-1:0]    ins_w_i,
  input  logic [PER_W-1:0] period_i,
  input  logic [CNT_W-1:0] pulses_i,
  input  logic [INS_W-1:0] max_ins_i,
  input  logic             cath_first_i,
  input  logic             resid_high_i,
  input  logic             resid_pos_i,
  output logic [AMP_W-1:0] amp_o,
  output logic             pol_o,
  output logic             short_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             fault_o
);
  function automatic logic [TW-1:0] ld(input logic [TW-1:0] w);
    return (w == '0) ? '0 : w - 1'b1;
  endfunction

  state_e state_q, state_d;

  // settings latched at start
  logic [AMP_W-1:0] amp_q;
  logic [TW-1:0]    phw_q, gap_q, shw_q, insw_q;
  logic [PER_W-1:0] per_q;
  logic [CNT_W-1:0] npul_q;
  logic [INS_W-1:0] maxi_q;
  logic             cath_q, ins_pol_q, done_q, fault_q;

  logic             tmr_load, tmr_zero;
  logic [TW-1:0]    tmr_val;
  logic             pc_clr, pul_clr, pul_inc, ins_clr, ins_inc;
  logic             set_fault, set_done, latch_cfg, ins_pol_set;
  logic [PER_W-1:0] pc;
  logic [CNT_W-1:0] pul_cnt;
  logic [INS_W-1:0] ins_cnt;
  logic             start_ok, last_pulse, period_up;

  assign start_ok   = start_i && !fault_q && (pulses_i != '0);
  assign last_pulse = ({1'b0, pul_cnt} + 1'b1) == {1'b0, npul_q};
  assign period_up  = ({1'b0, pc} + 1'b1) >= {1'b0, per_q};

  stim_timer #(.W(TW)) u_tmr (
    .clk_i, .rst_ni, .load_i(tmr_load), .val_i(tmr_val), .zero_o(tmr_zero)
  );
  stim_counter #(.W(PER_W)) u_pc (
    .clk_i, .rst_ni, .clr_i(pc_clr), .inc_i(1'b1), .cnt_o(pc)
  );
  stim_counter #(.W(CNT_W)) u_pul (
    .clk_i, .rst_ni, .clr_i(pul_clr), .inc_i(pul_inc), .cnt_o(pul_cnt)
  );
  stim_counter #(.W(INS_W)) u_ins (
    .clk_i, .rst_ni, .clr_i(ins_clr), .inc_i(ins_inc), .cnt_o(ins_cnt)
  );

  always_comb begin
    state_d     = state_q;
    tmr_load    = 1'b0;
    tmr_val     = '0;
    pc_clr      = 1'b0;
    pul_clr     = 1'b0;
    pul_inc     = 1'b0;
    ins_clr     = 1'b0;
    ins_inc     = 1'b0;
    set_fault   = 1'b0;
    set_done    = 1'b0;
    latch_cfg   = 1'b0;
    ins_pol_set = 1'b0;
    unique case (state_q)
      S_IDLE: if (start_ok) begin
        state_d   = S_PH1;
        tmr_load  = 1'b1;
        tmr_val   = ld(phase_w_i);
        pc_clr    = 1'b1;
        pul_clr   = 1'b1;
        ins_clr   = 1'b1;
        latch_cfg = 1'b1;
      end
      S_PH1: if (tmr_zero) begin
        tmr_load = 1'b1;
        if (gap_q == '0) begin
          state_d = S_PH2;
          tmr_val = ld(phw_q);
        end else begin
          state_d = S_GAP;
          tmr_val = ld(gap_q);
        end
      end
      S_GAP: if (tmr_zero) begin
        state_d  = S_PH2;
        tmr_load = 1'b1;
        tmr_val  = ld(phw_q);
      end
      S_PH2: if (tmr_zero) begin
        state_d  = S_SHORT;
        tmr_load = 1'b1;
        tmr_val  = ld(shw_q);
      end
      S_SHORT: if (tmr_zero) state_d = S_CHECK;
      S_CHECK: begin
        if (resid_high_i) begin
          if (ins_cnt == maxi_q) begin
            set_fault = 1'b1;
            state_d   = S_IDLE;
          end else begin
            state_d     = S_INSERT;
            tmr_load    = 1'b1;
            tmr_val     = ld(insw_q);
            ins_inc     = 1'b1;
            ins_pol_set = 1'b1;
          end
        end else begin
          pul_inc = 1'b1;
          if (last_pulse) begin
            set_done = 1'b1;
            state_d  = S_IDLE;
          end else begin
            state_d = S_WAIT;
          end
        end
      end
      S_INSERT: if (tmr_zero) state_d = S_CHECK;
      S_WAIT: if (period_up) begin
        state_d  = S_PH1;
        tmr_load = 1'b1;
        tmr_val  = ld(phw_q);
        pc_clr   = 1'b1;
        ins_clr  = 1'b1;
      end
      default: state_d = S_IDLE;
    endcase
    if (abort_i) begin
      state_d   = S_IDLE;
      set_fault = 1'b0;
      set_done  = 1'b0;
      latch_cfg = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      done_q    <= 1'b0;
      fault_q   <= 1'b0;
      ins_pol_q <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= set_done;
      fault_q <= fault_q | set_fault;
      // corrective polarity opposes the residual
      if (ins_pol_set) ins_pol_q <= !resid_pos_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      amp_q  <= '0;
      phw_q  <= '0;
      gap_q  <= '0;
      shw_q  <= '0;
      insw_q <= '0;
      per_q  <= '0;
      npul_q <= '0;
      maxi_q <= '0;
      cath_q <= 1'b0;
    end else if (latch_cfg) begin
      amp_q  <= amp_i;
      phw_q  <= phase_w_i;
      gap_q  <= gap_w_i;
      shw_q  <= short_w_i;
      insw_q <= ins_w_i;
      per_q  <= period_i;
      npul_q <= pulses_i;
      maxi_q <= max_ins_i;
      cath_q <= cath_first_i;
    end
  end

  always_comb begin
    amp_o = '0;
    pol_o = 1'b0;
    unique case (state_q)
      S_PH1:    begin amp_o = amp_q; pol_o = !cath_q;   end
      S_PH2:    begin amp_o = amp_q; pol_o = cath_q;    end
      S_INSERT: begin amp_o = amp_q; pol_o = ins_pol_q; end
      default:  ;
    endcase
  end

  assign short_o = (state_q == S_SHORT);
  assign busy_o  = (state_q != S_IDLE);
  assign done_o  = done_q;
  assign fault_o = fault_q;
endmodule

// File: rtl/stim_seq_chk.sv
module stim_seq_chk #(
  parameter int AMP_W = 8,
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             abort_i,
  input logic [CNT_W-1:0] pulses_i,
  input logic [AMP_W-1:0] amp_o,
  input logic             short_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             fault_o
);
  assert_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(short_o && amp_o != '0));

  assert_idle_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (amp_o == '0 && !short_o));

  assert_abort_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (!busy_o && amp_o == '0 && !short_o));

  assert_fault_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> fault_o);

  assert_fault_blocks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && !busy_o) |=> !busy_o);

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_start_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && !abort_i && !fault_o && pulses_i != '0) |=> busy_o);
endmodule

bind stim_seq stim_seq_chk #(.AMP_W(AMP_W), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .abort_i(abort_i),
  .pulses_i(pulses_i), .amp_o(amp_o), .short_o(short_o), .busy_o(busy_o),
  .done_o(done_o), .fault_o(fault_o)
);

// File: tb/tb_stim_seq.sv
module tb_stim_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, abort_i = 1'b0;
  logic [7:0]  amp_i = '0;
  logic [7:0]  phase_w_i = '0, gap_w_i = '0, short_w_i = '0, ins_w_i = '0;
  logic [11:0] period_i = '0;
  logic [7:0]  pulses_i = '0;
  logic [3:0]  max_ins_i = '0;
  logic        cath_first_i = 1'b0, resid_high_i = 1'b0, resid_pos_i = 1'b0;
  logic [7:0]  amp_o;
  logic        pol_o, short_o, busy_o, done_o, fault_o;

  int checks = 0, errors = 0, cyc = 0;

  stim_seq dut (.*);

  always #10 clk_i = ~clk_i;

  // amp, W, G, S, P, cath_first, N
  localparam int NV = 4;
  localparam int V_AMP[NV] = '{5, 200, 17, 9};
  localparam int V_W[NV]   = '{3, 1, 4, 2};
  localparam int V_G[NV]   = '{2, 0, 3, 1};
  localparam int V_S[NV]   = '{2, 1, 3, 2};
  localparam int V_P[NV]   = '{20, 8, 18, 0};
  localparam int V_C[NV]   = '{0, 1, 1, 0};
  localparam int V_N[NV]   = '{2, 3, 1, 2};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic adv();
    @(negedge clk_i);
    cyc++;
  endtask

  task automatic to_cyc(input int c);
    while (cyc < c) adv();
  endtask

  task automatic launch();
    start_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
    cyc = 0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic setup(input int a, input int w, input int g, input int s, input int p,
                       input int c, input int n, input int iw, input int mx);
    amp_i = 8'(a); phase_w_i = 8'(w); gap_w_i = 8'(g); short_w_i = 8'(s);
    period_i = 12'(p); cath_first_i = c[0]; pulses_i = 8'(n);
    ins_w_i = 8'(iw); max_ins_i = 4'(mx);
  endtask

  task automatic run_vec(input int i);
    int a, w, g, s, pe, n, len, tdone;
    bit cf;
    bit bad_amp, bad_pol, bad_sh, bad_done, bad_busy;
    a = V_AMP[i]; w = V_W[i]; g = V_G[i]; s = V_S[i]; cf = V_C[i][0]; n = V_N[i];
    len = 2 * w + g + s;
    pe = (V_P[i] > len + 2) ? V_P[i] : len + 2;
    tdone = (n - 1) * pe + len + 1;
    bad_amp = 0; bad_pol = 0; bad_sh = 0; bad_done = 0; bad_busy = 0;
    setup(a, w, g, s, V_P[i], V_C[i], n, 1, 1);
    resid_high_i = 1'b0;
    launch();
    for (int t = 0; t <= tdone + 2; t++) begin
      int r, ea, esh, edn, eb;
      bit ep;
      r = t % pe;
      ea = 0; ep = 0; esh = 0;
      if (t < tdone) begin
        if (r < w) begin ea = a; ep = !cf; end
        else if (r >= w + g && r < 2 * w + g) begin ea = a; ep = cf; end
        else if (r >= 2 * w + g && r < len) esh = 1;
      end
      edn = (t == tdone) ? 1 : 0;
      eb  = (t < tdone) ? 1 : 0;
      if (int'(amp_o) != ea && !bad_amp) begin
        bad_amp = 1;
        chk(0, $sformatf("R2 R3 R5 amp vec%0d t%0d", i, t), int'(amp_o), ea);
      end
      if (ea != 0 && pol_o != ep && !bad_pol) begin
        bad_pol = 1;
        chk(0, $sformatf("R2 polarity vec%0d t%0d", i, t), int'(pol_o), int'(ep));
      end
      if (int'(short_o) != esh && !bad_sh) begin
        bad_sh = 1;
        chk(0, $sformatf("R4 short vec%0d t%0d", i, t), int'(short_o), esh);
      end
      if (int'(done_o) != edn && !bad_done) begin
        bad_done = 1;
        chk(0, $sformatf("R8 done vec%0d t%0d", i, t), int'(done_o), edn);
      end
      if (int'(busy_o) != eb && !bad_busy) begin
        bad_busy = 1;
        chk(0, $sformatf("R8 busy vec%0d t%0d", i, t), int'(busy_o), eb);
      end
      adv();
    end
    if (!bad_amp)  chk(1, "R2", 0, 0);
    if (!bad_pol)  chk(1, "R2", 0, 0);
    if (!bad_sh)   chk(1, "R4", 0, 0);
    if (!bad_done) chk(1, "R8", 0, 0);
    if (!bad_busy) chk(1, "R5", 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n_ins;
    // R1 reset state
    repeat (2) @(negedge clk_i);
    chk(amp_o == 0 && !short_o && !busy_o && !done_o && !fault_o && !pol_o,
        "R1 reset outputs", int'(busy_o), 0);
    do_reset();
    chk(amp_o == 0 && !busy_o && !fault_o, "R1 after release", int'(amp_o), 0);

    for (int i = 0; i < NV; i++) run_vec(i);

    // R10 start with zero pulse count is ignored
    setup(4, 2, 1, 1, 10, 0, 0, 1, 1);
    launch();
    adv();
    chk(!busy_o && amp_o == 0, "R10 zero count ignored", int'(busy_o), 0);

    // R10 settings latched at start
    setup(6, 3, 1, 1, 20, 0, 1, 1, 1);
    launch();
    amp_i = 8'd99;
    adv();
    chk(int'(amp_o) == 6, "R10 amplitude latched", int'(amp_o), 6);
    to_cyc(12);
    chk(!busy_o, "R10 latched train ends", int'(busy_o), 0);

    // R9 abort mid-phase
    setup(11, 5, 2, 2, 30, 0, 3, 1, 1);
    launch();
    adv(); adv();
    abort_i = 1'b1;
    adv();
    abort_i = 1'b0;
    chk(!busy_o && amp_o == 0 && !short_o, "R9 abort idles", int'(amp_o), 0);
    adv(); adv();
    chk(!done_o && !fault_o, "R9 abort gives no done", int'(done_o), 0);

    // R6 two corrective pulses then safe: residual positive -> pol 0
    setup(7, 2, 1, 2, 40, 0, 1, 3, 3);
    resid_high_i = 1'b1; resid_pos_i = 1'b1;
    launch();
    n_ins = 0;
    to_cyc(7);
    chk(amp_o == 0 && !short_o && busy_o, "R6 check cycle quiet", int'(amp_o), 0);
    adv();
    chk(int'(amp_o) == 7 && pol_o == 1'b0 && !short_o, "R6 insert polarity", int'(pol_o), 0);
    while (cyc <= 14) begin
      if (amp_o != 0) n_ins++;
      if (cyc == 13) resid_high_i = 1'b0;
      adv();
    end
    chk(n_ins == 6, "R6 corrective cycles", n_ins, 6);
    to_cyc(16);
    chk(done_o && !fault_o && !busy_o, "R6 R8 done after safe check", int'(done_o), 1);

    // R7 cap reached; residual negative -> pol 1
    setup(7, 2, 1, 2, 40, 0, 2, 3, 2);
    resid_high_i = 1'b1; resid_pos_i = 1'b0;
    launch();
    to_cyc(8);
    chk(int'(amp_o) == 7 && pol_o == 1'b1, "R6 insert opposite negative", int'(pol_o), 1);
    to_cyc(15);
    chk(!fault_o && busy_o, "R7 fault not yet", int'(fault_o), 0);
    adv();
    chk(fault_o && !busy_o && !done_o, "R7 fault at cap", int'(fault_o), 1);
    resid_high_i = 1'b0;
    launch();
    adv();
    chk(!busy_o && fault_o, "R7 start ignored while fault", int'(busy_o), 0);
    do_reset();
    chk(!fault_o, "R1 R7 reset clears fault", int'(fault_o), 0);

    // R7 cap of zero faults at first high check
    setup(3, 2, 1, 2, 40, 1, 1, 3, 0);
    resid_high_i = 1'b1;
    launch();
    to_cyc(8);
    chk(fault_o && !busy_o, "R7 zero cap", int'(fault_o), 1);
    resid_high_i = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule